// File: doc/BRIEF.md
# Retired-Instruction Counter with Write Override

This block keeps a 64-bit count of retired instructions for an in-order pipelined processor and exposes it to CSR instructions as two 32-bit halves. The execute stage signals, once per cycle, that an instruction which counts has finished and is moving into writeback. That instruction's effect on the counter lands one cycle later, when it retires. A CSR read issued in execute right behind such an instruction must still see it counted. The block therefore keeps a one-cycle pending flag and adds it speculatively to the read value.

The flag lasts exactly one cycle. A bubble clears it, so a value that the counter has already absorbed is never added a second time. An explicit CSR write decides the next counter value outright. Any pending increment is folded in before the write is applied, and the writing instruction's own increment is dropped. As a result, the instruction after a write reads exactly the value that was written. An inhibit input freezes counting without blocking writes.

Top module: `retire_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the counter, the read data and the pending flag all become zero.
- R2: A single `instr_done_i` pulse in cycle t, with no write and no inhibit, raises `count_o` by exactly one at the rising edge that ends cycle t+1.
- R3: A read in cycle t returns the selected half of the counter plus one when the previous cycle had a counting `instr_done_i` that was not a write. After a cycle with no `instr_done_i`, no extra one is added.
- R4: A read returns the value from before the reading instruction's own retirement, even when `instr_done_i` is high in the same cycle.
- R5: A write in cycle t sets the selected half to `csr_wdata_i` at the end of cycle t. The writing instruction adds no increment, so a read in cycle t+1 returns the written value exactly.
- R6: A write to one half leaves the other half equal to what a read in that cycle would have returned. Half select `csr_hi_i` = 0 picks bits 31:0 and 1 picks bits 63:32.
- R7: An increment that overflows the low half carries into the high half at the same clock edge.
- R8: While `inhibit_i` is high, no retirement increment is applied. Writes still take effect.
- R9: `csr_rdata_o` is registered. It updates at the edge that ends a read cycle and holds its value when `csr_rd_i` is low.
- R10: `spec_inc_o` is high in the cycle after a cycle with `instr_done_i` high and `csr_we_i` low, and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done_i | input | 1 | A counting instruction leaves execute this cycle |
| inhibit_i | input | 1 | Suppress retirement increments |
| csr_rd_i | input | 1 | CSR read of the counter this cycle |
| csr_we_i | input | 1 | CSR write of the counter this cycle |
| csr_hi_i | input | 1 | Half select: 0 low word, 1 high word |
| csr_wdata_i | input | 32 | Write data for the selected half |
| csr_rdata_o | output | 32 | Registered read data |
| count_o | output | 64 | Current committed counter value |
| spec_inc_o | output | 1 | A retirement is pending and not yet counted |

## Verification
The results fall due at different times. `spec_inc_o` follows a `instr_done_i` pulse at the next rising edge, while `count_o` absorbs that retirement one edge later. A write shows on `count_o` at the edge that ends the write cycle, and `csr_rdata_o` holds a read result from the edge that ends the read cycle. The bench drives each cycle's inputs on the falling edge and advances a reference model by one cycle with the same inputs. It samples every output shortly after the following rising edge, so each result is compared in exactly the cycle the model says it becomes due.

// File: rtl/rc_pkg.sv
package rc_pkg;
  // Which CSR half an access targets
  typedef enum logic {
    PART_LO = 1'b0,
    PART_HI = 1'b1
  } part_sel_e;

  // Number of CSR-visible slices of the counter
  localparam int RC_PARTS = 2;
endpackage

// File: rtl/rc_pend_track.sv
module rc_pend_track (
  input  logic clk,
  input  logic rst,
  input  logic done_i,
  input  logic we_i,
  output logic pend_o
);
  logic pend_q;

  // Valid for exactly one cycle: a bubble clears it, so nothing stale remains
  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= done_i & ~we_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/rc_count_core.sv
module rc_count_core #(
  parameter int CNT_W = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pend_i,
  input  logic                     inhibit_i,
  input  logic                     we_i,
  input  rc_pkg::part_sel_e        sel_i,
  input  logic [CNT_W/rc_pkg::RC_PARTS-1:0] wdata_i,
  output logic [CNT_W-1:0]         count_o,
  output logic [CNT_W-1:0]         visible_o
);
  localparam int NPARTS = rc_pkg::RC_PARTS;
  localparam int PART_W = CNT_W / NPARTS;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             inc;

  assign inc       = pend_i & ~inhibit_i;
  // Full-width add keeps the low-to-high carry in the same edge
  assign visible_o = cnt_q + {{(CNT_W-1){1'b0}}, inc};

  generate
    for (genvar p = 0; p < NPARTS; p++) begin : g_part
      logic hit;
      assign hit = we_i && (sel_i == rc_pkg::part_sel_e'(p));
      assign cnt_nxt[p*PART_W +: PART_W] =
        hit ? wdata_i : visible_o[p*PART_W +: PART_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/rc_read_port.sv
module rc_read_port #(
  parameter int CNT_W = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_i,
  input  rc_pkg::part_sel_e    sel_i,
  input  logic [CNT_W-1:0]     visible_i,
  output logic [CNT_W/2-1:0]   rdata_o
);
  localparam int PART_W = CNT_W / 2;

  logic [PART_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      rdata_q <= (sel_i == rc_pkg::PART_HI) ? visible_i[CNT_W-1:PART_W]
                                            : visible_i[PART_W-1:0];
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/retire_counter.sv
module retire_counter #(
  parameter int CNT_W  = 64,
  parameter int PART_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_done_i,
  input  logic              inhibit_i,
  input  logic              csr_rd_i,
  input  logic              csr_we_i,
  input  logic              csr_hi_i,
  input  logic [PART_W-1:0] csr_wdata_i,
  output logic [PART_W-1:0] csr_rdata_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              spec_inc_o
);
  rc_pkg::part_sel_e sel;
  logic              pend;
  logic [CNT_W-1:0]  visible;

  assign sel = rc_pkg::part_sel_e'(csr_hi_i);

  rc_pend_track u_pend (
    .clk    (clk),
    .rst    (rst),
    .done_i (instr_done_i),
    .we_i   (csr_we_i),
    .pend_o (pend)
  );

  rc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .pend_i    (pend),
    .inhibit_i (inhibit_i),
    .we_i      (csr_we_i),
    .sel_i     (sel),
    .wdata_i   (csr_wdata_i),
    .count_o   (count_o),
    .visible_o (visible)
  );

  rc_read_port #(.CNT_W(CNT_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_i      (csr_rd_i),
    .sel_i     (sel),
    .visible_i (visible),
    .rdata_o   (csr_rdata_o)
  );

  assign spec_inc_o = pend;
endmodule

// File: rtl/retire_counter_chk.sv
module retire_counter_chk #(
  parameter int CNT_W  = 64,
  parameter int PART_W = CNT_W / 2
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_done_i,
  input logic              inhibit_i,
  input logic              csr_rd_i,
  input logic              csr_we_i,
  input logic              csr_hi_i,
  input logic [PART_W-1:0] csr_wdata_i,
  input logic [PART_W-1:0] csr_rdata_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              spec_inc_o
);
  assert_pend_set_R10: assert property (@(posedge clk) disable iff (rst)
    (instr_done_i && !csr_we_i) |=> spec_inc_o);

  assert_pend_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (!instr_done_i || csr_we_i) |=> !spec_inc_o);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!csr_we_i && spec_inc_o && !inhibit_i) |=> (count_o == $past(count_o) + 1'b1));

  assert_count_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!csr_we_i && (inhibit_i || !spec_inc_o)) |=> $stable(count_o));

  assert_write_lo_R5: assert property (@(posedge clk) disable iff (rst)
    (csr_we_i && !csr_hi_i) |=> (count_o[PART_W-1:0] == $past(csr_wdata_i)));

  assert_write_hi_R6: assert property (@(posedge clk) disable iff (rst)
    (csr_we_i && csr_hi_i) |=> (count_o[CNT_W-1:PART_W] == $past(csr_wdata_i)));

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !csr_rd_i |=> $stable(csr_rdata_o));
endmodule

bind retire_counter retire_counter_chk #(.CNT_W(CNT_W), .PART_W(PART_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .instr_done_i (instr_done_i),
  .inhibit_i    (inhibit_i),
  .csr_rd_i     (csr_rd_i),
  .csr_we_i     (csr_we_i),
  .csr_hi_i     (csr_hi_i),
  .csr_wdata_i  (csr_wdata_i),
  .csr_rdata_o  (csr_rdata_o),
  .count_o      (count_o),
  .spec_inc_o   (spec_inc_o)
);

// File: tb/sim_retire_counter.sv
module sim_retire_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_done_i = 1'b0;
  logic        inhibit_i = 1'b0;
  logic        csr_rd_i = 1'b0;
  logic        csr_we_i = 1'b0;
  logic        csr_hi_i = 1'b0;
  logic [31:0] csr_wdata_i = '0;
  logic [31:0] csr_rdata_o;
  logic [63:0] count_o;
  logic        spec_inc_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  logic [63:0] m_cnt  = '0;
  logic        m_pend = 1'b0;
  logic [31:0] m_rd   = '0;

  always #10 clk = ~clk;  // 50 MHz

  retire_counter u0 (
    .clk          (clk),
    .rst          (rst),
    .instr_done_i (instr_done_i),
    .inhibit_i    (inhibit_i),
    .csr_rd_i     (csr_rd_i),
    .csr_we_i     (csr_we_i),
    .csr_hi_i     (csr_hi_i),
    .csr_wdata_i  (csr_wdata_i),
    .csr_rdata_o  (csr_rdata_o),
    .count_o      (count_o),
    .spec_inc_o   (spec_inc_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, advance model, sample after rising edge
  task automatic step(input logic done, input logic we, input logic rd,
                      input logic hi, input logic inh, input logic [31:0] wd,
                      input string tag);
    logic [63:0] vis;
    @(negedge clk);
    instr_done_i = done; csr_we_i = we; csr_rd_i = rd;
    csr_hi_i = hi; inhibit_i = inh; csr_wdata_i = wd;
    vis = m_cnt + {63'd0, m_pend & ~inh};
    if (rd) m_rd = hi ? vis[63:32] : vis[31:0];
    if (we) begin
      if (hi) vis[63:32] = wd;
      else    vis[31:0]  = wd;
    end
    m_cnt  = vis;
    m_pend = done & ~we;
    @(posedge clk);
    #2;
    chk(tag, "count", count_o, m_cnt);
    chk("R10", "spec", {63'd0, spec_inc_o}, {63'd0, m_pend});
    chk("R9", "rdata", {32'd0, csr_rdata_o}, {32'd0, m_rd});
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0, tag);
  endtask

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "count", count_o, 64'd0);
    chk("R1", "spec", {63'd0, spec_inc_o}, 64'd0);
    chk("R1", "rdata", {32'd0, csr_rdata_o}, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // R2: single retirement lands one edge after the pending flag
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0, "R2");
    idle("R2");
    idle("R2");
    chk("R2", "count after one", count_o, 64'd1);

    // R3: back-to-back read sees the pending instruction
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0, "R3");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'd0, "R3");
    chk("R3", "read spec", {32'd0, csr_rdata_o}, 64'd2);
    // R3: after a bubble no extra one is added
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0, "R3");
    idle("R3");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'd0, "R3");
    chk("R3", "read after bubble", {32'd0, csr_rdata_o}, 64'd3);

    // R4: reading instruction's own retirement not visible
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'd0, "R4");
    chk("R4", "read excludes self", {32'd0, csr_rdata_o}, 64'd3);
    idle("R4");

    // R5: write with pending retirement, next instruction reads written value
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0, "R5");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_0100, "R5");
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'd0, "R5");
    chk("R5", "read after write", {32'd0, csr_rdata_o}, 64'h100);

    // R6: high write keeps low half
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'hABCD_0001, "R6");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'd0, "R6");
    chk("R6", "low kept", {32'd0, csr_rdata_o}, 64'h101);

    // R7: carry from low into high
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, "R7");
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_0005, "R7");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0, "R7");
    idle("R7");
    chk("R7", "carry", count_o, 64'h0000_0006_0000_0000);

    // R8: inhibit freezes counting but writes go through
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'd0, "R8");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'd0, "R8");
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_0042, "R8");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'd0, "R8");
    chk("R8", "write under inhibit", {32'd0, csr_rdata_o}, 64'h42);

    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic d, w, r, h, n;
      logic [31:0] v;
      d = ($urandom % 4) != 0;
      w = ($urandom % 10) == 0;
      r = ($urandom % 3) == 0;
      h = $urandom % 2;
      n = ($urandom % 12) == 0;
      v = (($urandom % 4) == 0) ? 32'hFFFF_FFF0 + ($urandom % 16) : $urandom;
      step(d, w, r, h, n, v, "R3");
    end

    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule